// File: doc/BRIEF.md
# Power-Cycling Interval Timer Controller

This block keeps an external power switch open for a long, selectable interval, then closes it to wake a downstream system. It waits for that system to acknowledge that its work is finished. The switch enable `sw_en_n` is active low: it idles high and goes low to turn the switch on.

While the switch is on, a calibration pulse `cal_pulse` is produced. It is one oscillator period wide. The downstream system can measure its width to learn the true oscillator period.

A `done_in` pulse during the on-window ends the window early. If no acknowledgment arrives, the window closes by itself after two oscillator periods. The next interval then starts.

A power-good input supervises the whole sequence. When it is low, the block is cleared asynchronously and held idle. Each rise of power-good starts a full delay.

The block runs from a clock at twice the oscillator rate, so one clock cycle is one half-tick. All timing below is counted in rising clock edges. The parameter `SCALE_SHIFT` divides every delay by 2^SCALE_SHIFT. The default is 0, which gives the full-length intervals.

Top module: `pwr_cycle_timer`

## Requirements
- R1: The 3-bit select `dly_sel` picks the delay in oscillator periods: 0→1024, 1→2048, 2→4096, 3→6400, 4→8192, 5→16384, 6→32768, 7→65536. The result is shifted right by SCALE_SHIFT. The delay in clock edges is L = 2 × periods.
- R2: While `rst_n` is low, `sw_en_n` is 1 and `cal_pulse` is 0.
- R3: After release of reset (or of power-good), `sw_en_n` stays 1 through edge L-1 and goes low on rising edge L.
- R4: With no acknowledgment, `sw_en_n` stays low for exactly 4 edges, then returns high. The next fall comes exactly L edges after that rise.
- R5: `cal_pulse` rises one edge after `sw_en_n` falls and stays high for exactly 2 edges. It is never high while `sw_en_n` is high.
- R6: A `done_in` pulse of any width, even shorter than a clock period, is caught while the window is open. If it rises between edges k-1 and k, then at edge k+1 `sw_en_n` goes high and `cal_pulse` goes low, even in the middle of the calibration pulse. The next fall is L edges after that rise.
- R7: A `done_in` pulse while `sw_en_n` is high has no effect on when the next fall occurs.
- R8: When `pwr_ok` is low, `sw_en_n` is forced to 1 and `cal_pulse` to 0 at once, with no clock needed. The block stays idle while `pwr_ok` is low. When it rises, a full delay L elapses before the next fall.
- R9: `dly_sel` is sampled once, on the first edge of each delay. A change made during a count applies only to the following delay.
- R10: An acknowledgment recognized on the same edge as the window timeout restarts the delay once. The next fall is exactly L edges after the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-tick clock, twice the oscillator rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_ok | input | 1 | Power-good supervision; low clears and holds the block asynchronously |
| done_in | input | 1 | Acknowledgment from the woken system, captured asynchronously |
| dly_sel | input | 3 | Delay select code |
| sw_en_n | output | 1 | Power switch enable, active low |
| cal_pulse | output | 1 | Calibration pulse, one oscillator period wide |

## Verification
The acknowledgment and the window timeout can land on the same clock edge. The bench provokes this by raising `done_in` between the second and third edge of the window. The result is judged from the port timing: the rise must come on the fourth window edge, and the next fall exactly L edges later, with no extra restart.

A second overlap is a power-good drop while the calibration pulse is high. Both outputs must return to idle before the next edge. The following fall must wait a full delay after power-good returns.

// File: rtl/pct_pkg.sv
package pct_pkg;

  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_COUNT = 2'd1,
    ST_ON    = 2'd2
  } pct_state_e;

  // On-window length and calibration span, in half-ticks
  localparam int unsigned WIN_HT    = 4;
  localparam int unsigned PH_W      = 2;
  localparam int unsigned CAL_FIRST = 1;
  localparam int unsigned CAL_LAST  = 2;
  localparam int unsigned MAX_PER   = 65536;

  // Delay select code to oscillator periods, scaled down by 2^shift
  function automatic int unsigned sel_to_periods(input logic [2:0] sel,
                                                 input int unsigned shift);
    int unsigned p;
    case (sel)
      3'd0:    p = 32'd1 << 10;
      3'd1:    p = 32'd1 << 11;
      3'd2:    p = 32'd1 << 12;
      3'd3:    p = 32'd100 << 6;
      3'd4:    p = 32'd1 << 13;
      3'd5:    p = 32'd1 << 14;
      3'd6:    p = 32'd1 << 15;
      default: p = 32'd1 << 16;
    endcase
    return p >> shift;
  endfunction

  function automatic int unsigned periods_to_halfticks(input int unsigned p);
    return 2 * p;
  endfunction

endpackage

// File: rtl/pct_delay_decode.sv
module pct_delay_decode #(
  parameter int unsigned SCALE_SHIFT = 0,
  parameter int unsigned CNT_W       = 18
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             load,
  input  logic [2:0]       sel_in,
  output logic [CNT_W-1:0] limit_ht
);
  import pct_pkg::*;

  logic [2:0] sel_q;

  // Select is captured only on the first edge of a delay
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)   sel_q <= 3'd0;
    else if (load) sel_q <= sel_in;
  end

  always_comb begin
    limit_ht = CNT_W'(periods_to_halfticks(sel_to_periods(sel_q, SCALE_SHIFT)));
  end

  // R1
  always_comb begin
    if (sel_q != 3'd3) begin
      dly_pow2_chk: assert ($onehot(limit_ht));
    end
  end

endmodule

// File: rtl/pct_done_catch.sv
module pct_done_catch (
  input  logic clk,
  input  logic arst_n,
  input  logic done_in,
  input  logic arm,
  output logic done_seen
);

  logic cap_q;
  logic retime_q;

  // Asynchronous-set catcher: a short pulse is held until the window closes
  always_ff @(posedge clk or posedge done_in or negedge arst_n) begin
    if (!arst_n)              cap_q <= 1'b0;
    else if (done_in && arm)  cap_q <= 1'b1;
    else if (!arm)            cap_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) retime_q <= 1'b0;
    else         retime_q <= cap_q;
  end

  assign done_seen = retime_q;

endmodule

// File: rtl/pct_phase_seq.sv
module pct_phase_seq #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [CNT_W-1:0] limit_ht,
  input  logic             done_seen,
  output logic             load,
  output logic             arm,
  output logic             sw_en_n,
  output logic             cal_pulse
);
  import pct_pkg::*;

  pct_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PH_W-1:0]  ph_q, ph_d;

  logic delay_done;
  logic win_end;
  logic ack_hit;

  assign delay_done = (state_q == ST_COUNT) && (cnt_q == limit_ht - CNT_W'(1));
  assign win_end    = (state_q == ST_ON) && (ph_q == PH_W'(WIN_HT - 1));
  assign ack_hit    = (state_q == ST_ON) && done_seen;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ph_d    = ph_q;
    case (state_q)
      ST_LOAD: begin
        // The load edge counts as the first half-tick of the delay
        state_d = ST_COUNT;
        cnt_d   = CNT_W'(1);
      end
      ST_COUNT: begin
        if (delay_done) begin
          state_d = ST_ON;
          cnt_d   = '0;
          ph_d    = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_ON: begin
        if (ack_hit || win_end) state_d = ST_LOAD;
        else                    ph_d    = ph_q + PH_W'(1);
      end
      default: state_d = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_LOAD;
      cnt_q   <= '0;
      ph_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ph_q    <= ph_d;
    end
  end

  assign load      = (state_q == ST_LOAD);
  assign arm       = (state_q == ST_ON);
  assign sw_en_n   = (state_q != ST_ON);
  assign cal_pulse = (state_q == ST_ON) &&
                     (ph_q >= PH_W'(CAL_FIRST)) && (ph_q <= PH_W'(CAL_LAST));

  // Checker state: length of the current low run of the enable
  logic [2:0] low_run_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)       low_run_q <= '0;
    else if (!sw_en_n) low_run_q <= low_run_q + 3'd1;
    else               low_run_q <= '0;
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_COUNT) |-> (cnt_q != '0) && (cnt_q < limit_ht));

  // R4
  win_len_chk: assert property (@(posedge clk) disable iff (!arst_n)
    low_run_q <= 3'(WIN_HT));

  // R5
  cal_follows_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(sw_en_n) |=> cal_pulse);

  // R5
  cal_width_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (cal_pulse && $past(cal_pulse)) |=> !cal_pulse);

  // R5
  cal_inside_chk: assert property (@(posedge clk) disable iff (!arst_n)
    cal_pulse |-> !sw_en_n);

  // R6
  ack_exit_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!sw_en_n && done_seen) |=> (sw_en_n && !cal_pulse));

endmodule

// File: rtl/pwr_cycle_timer.sv
module pwr_cycle_timer #(
  parameter int unsigned SCALE_SHIFT = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_ok,
  input  logic       done_in,
  input  logic [2:0] dly_sel,
  output logic       sw_en_n,
  output logic       cal_pulse
);
  import pct_pkg::*;

  localparam int unsigned MAX_HT = periods_to_halfticks(MAX_PER >> SCALE_SHIFT);
  localparam int unsigned CNT_W  = $clog2(MAX_HT + 1);

  // Power-good joins the reset: its fall clears every flop at once
  logic             arst_n;
  logic [CNT_W-1:0] limit_ht;
  logic             load;
  logic             arm;
  logic             done_seen;

  assign arst_n = rst_n & pwr_ok;

  pct_delay_decode #(
    .SCALE_SHIFT(SCALE_SHIFT),
    .CNT_W      (CNT_W)
  ) u_decode (
    .clk     (clk),
    .arst_n  (arst_n),
    .load    (load),
    .sel_in  (dly_sel),
    .limit_ht(limit_ht)
  );

  pct_done_catch u_catch (
    .clk      (clk),
    .arst_n   (arst_n),
    .done_in  (done_in),
    .arm      (arm),
    .done_seen(done_seen)
  );

  pct_phase_seq #(
    .CNT_W(CNT_W)
  ) u_seq (
    .clk      (clk),
    .arst_n   (arst_n),
    .limit_ht (limit_ht),
    .done_seen(done_seen),
    .load     (load),
    .arm      (arm),
    .sw_en_n  (sw_en_n),
    .cal_pulse(cal_pulse)
  );

  // R8
  pg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> (sw_en_n && !cal_pulse));

endmodule

// File: tb/pwr_cycle_timer_tb_top.sv
`timescale 1ns/1ps
module pwr_cycle_timer_tb_top;

  localparam int SHIFT = 6;
  localparam int NV    = 8;
  // {sel, done offset after fall edge (4 = none), expected exit edge}
  localparam logic [8:0] VEC [NV] = '{
    {3'd0, 3'd4, 3'd4}, {3'd1, 3'd0, 3'd2}, {3'd2, 3'd1, 3'd3}, {3'd3, 3'd2, 3'd4},
    {3'd4, 3'd3, 3'd4}, {3'd5, 3'd4, 3'd4}, {3'd6, 3'd0, 3'd2}, {3'd7, 3'd1, 3'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0, pwr_ok = 1'b1, done_in = 1'b0;
  logic [2:0] dly_sel = 3'd0;
  logic sw_en_n, cal_pulse;
  int n_chk = 0, n_fail = 0;
  bit reported = 1'b0;

  always #2 clk = ~clk;

  pwr_cycle_timer #(.SCALE_SHIFT(SHIFT)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .done_in(done_in),
    .dly_sel(dly_sel), .sw_en_n(sw_en_n), .cal_pulse(cal_pulse)
  );

  function automatic int exp_ht(input int sel);
    int p;
    if (sel == 3)     p = 6400;
    else if (sel < 3) p = 1024 << sel;
    else              p = 8192 << (sel - 4);
    return 2 * (p >> SHIFT);
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic tickn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_done();
    done_in = 1'b1;
    #0.5 done_in = 1'b0;
  endtask

  task automatic restart();
    pwr_ok = 1'b0;
    tickn(2);
    pwr_ok = 1'b1;
  endtask

  // Wait n edges; enable must be high one edge before and low on edge n
  task automatic wait_fall(input int n, input string req);
    tickn(n - 1);
    check(req, "enable before fall", sw_en_n, 1'b1);
    tick();
    check(req, "enable at fall", sw_en_n, 1'b0);
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    // R2 reset state
    tickn(3);
    check("R2", "enable in reset", sw_en_n, 1'b1);
    check("R2", "cal in reset", cal_pulse, 1'b0);
    rst_n = 1'b1;
    wait_fall(exp_ht(0), "R3");

    // R5 then R8: power-good drop while calibration pulse is high
    tick();
    check("R5", "cal one edge after fall", cal_pulse, 1'b1);
    #0.5 pwr_ok = 1'b0;
    #0.5;
    check("R8", "enable forced", sw_en_n, 1'b1);
    check("R8", "cal forced", cal_pulse, 1'b0);
    begin
      logic bad = 1'b0;
      for (int i = 0; i < 40; i++) begin
        tick();
        if (sw_en_n !== 1'b1 || cal_pulse !== 1'b0) bad = 1'b1;
      end
      check("R8", "held idle while low", bad, 1'b0);
    end
    pwr_ok = 1'b1;
    wait_fall(exp_ht(0), "R8");

    // R9: select change during a count applies only to the next delay
    tickn(4);
    check("R4", "rise after timeout", sw_en_n, 1'b1);
    tickn(5);
    dly_sel = 3'd1;
    wait_fall(exp_ht(0) - 5, "R9");
    tickn(4);
    check("R4", "rise after timeout", sw_en_n, 1'b1);
    wait_fall(exp_ht(1), "R9");

    // R7: acknowledgment outside the window is ignored
    tickn(4);
    tickn(3);
    pulse_done();
    tickn(10);
    pulse_done();
    wait_fall(exp_ht(1) - 13, "R7");

    // Vector table: R1, R4, R5, R6, R10
    for (int v = 0; v < NV; v++) begin
      int sel = int'(VEC[v][8:6]);
      int d   = int'(VEC[v][5:3]);
      int ex  = int'(VEC[v][2:0]);
      int L   = exp_ht(sel);
      string rq = (d == 2) ? "R10" : ((d < 4) ? "R6" : "R4");
      dly_sel = 3'(sel);
      restart();
      wait_fall(L, "R1");
      for (int j = 1; j <= 4; j++) begin
        if (d == j - 1) pulse_done();
        tick();
        check(rq, "enable in window", sw_en_n, (j >= ex) ? 1'b1 : 1'b0);
        check("R5", "cal in window", cal_pulse,
              (j < ex && (j == 1 || j == 2)) ? 1'b1 : 1'b0);
      end
      wait_fall(L - (4 - ex), rq);
    end

    report();
  end

endmodule